// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Time Insertion

This block turns one period/duty setting into two complementary pulse-width outputs: a primary pin and a secondary pin. A shared period counter advances on each counter-domain clock enable. Its compare result sets which side of the pair should be active. Each time that result changes, the output that is giving up its active state drops at once. The output that is taking over waits for a programmable dead interval of up to 255 ticks before it becomes active. Between the two active phases, both pins therefore sit at their inactive levels.

The primary output's active level is programmable. The secondary output always uses the opposite active level. The pair runs only when dead-time insertion is enabled and the active count is at least the dead count. Otherwise the block raises an error flag and holds both pins inactive. Clearing the pair enable stops the counter, clears the error flag and parks both pins at their inactive levels. The next enable starts the waveform again from the top of the period.

Top module: `cpwm_pair`

## Requirements
- R1: After reset, with the pair disabled, the primary pin is at the inverse of `pri_act_lvl`, the secondary pin is at `pri_act_lvl`, and `cfg_err` is 0.
- R2: The period is `period_last`+1 ticks. In each period the primary pin is active (equal to `pri_act_lvl`) for `active_cnt` − `dead_cnt` ticks.
- R3: The secondary pin's active level is the inverse of `pri_act_lvl`. It is active for (`period_last`+1) − `active_cnt` − `dead_cnt` ticks per period.
- R4: While dead-time insertion is enabled, the two pins are never active in the same cycle.
- R5: Whenever one output stops being active, both pins stay inactive for `dead_cnt` ticks before the other output becomes active. Each period therefore holds 2×`dead_cnt` ticks in which both are inactive. This also holds at the largest dead count, 255.
- R6: The counter and the dead interval advance only in cycles where `tick_en` is 1. Holding `tick_en` low for k−1 of every k cycles stretches every duration by k.
- R7: With the pair enabled, `cfg_err` rises one cycle after `active_cnt` < `dead_cnt` and stays high while that holds. Both pins are inactive while `cfg_err` is 1. Once the counts are corrected, the flag clears and the pair runs.
- R8: With the pair enabled and `dz_en` at 0, `cfg_err` rises one cycle later and both pins stay inactive.
- R9: One cycle after `pair_en` goes to 0, both pins are inactive and `cfg_err` is 0. With a tick in every cycle, the primary pin first becomes active `dead_cnt`+2 cycles after `pair_en` is raised, and the secondary pin stays inactive until then.
- R10: With `pri_act_lvl` at 0, the primary pin is active low and the secondary pin active high, with the same durations as in R2 and R3.
- R11: With `dead_cnt` at 0, the pins are exact complements. The primary pin is active for `active_cnt` ticks and the secondary pin for the rest of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter-domain clock enable, one tick per high cycle |
| period_last | input | CNT_W | Last count of the period (period length minus one) |
| active_cnt | input | CNT_W | Ticks per period during which the primary side is requested |
| pri_act_lvl | input | 1 | Active level of the primary pin; the secondary pin uses the inverse |
| dz_en | input | 1 | Dead-time insertion enable; must be 1 for the pair to run |
| dead_cnt | input | DEAD_W | Dead interval in ticks |
| pair_en | input | 1 | Pair enable |
| pwm_pri | output | 1 | Primary output pin |
| pwm_sec | output | 1 | Secondary output pin |
| cfg_err | output | 1 | Configuration error: duty shorter than dead time, or dead-time insertion disabled |

## Verification
Two situations are hard to reach from the pins: the dead interval at its full 255-tick width, and a duty that becomes legal while the pair is already enabled. Both depend on long tick sequences and on changing a count mid-run rather than from reset. The stimulus reaches the 255-tick case with a 600-tick period and counts every cycle of a whole period. It reaches the mid-run correction by raising `active_cnt` past `dead_cnt` while `pair_en` stays high, then confirms the error flag drops and pulses appear. Duration checks count active, overlapping and idle cycles over whole periods, so they do not depend on where in the period the measurement starts.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   // Which side of the pair the period compare currently requests.
   typedef enum logic {
      PH_SEC = 1'b0,
      PH_PRI = 1'b1
   } phase_t;

   // Channel index inside the pair.
   localparam int CH_PRI = 0;
   localparam int CH_SEC = 1;
   localparam int N_CH   = 2;

   // Pin level for a channel given its activity and its active level.
   function automatic logic pin_level(input logic act, input logic act_lvl);
      return act ? act_lvl : ~act_lvl;
   endfunction

endpackage

// File: rtl/cpwm_cfg_check.sv
module cpwm_cfg_check #(
   parameter int CNT_W  = 16,
   parameter int DEAD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pair_en,
   input  logic             dz_en,
   input  logic [CNT_W-1:0] active_cnt,
   input  logic [DEAD_W-1:0] dead_cnt,
   output logic             run_q,
   output logic             err_q
);

   logic [CNT_W-1:0] dead_ext;
   logic             short_duty;
   logic             cfg_bad;

   assign dead_ext   = CNT_W'(dead_cnt);
   assign short_duty = (active_cnt < dead_ext);
   assign cfg_bad    = ~dz_en | short_duty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         run_q <= pair_en & ~cfg_bad;
         err_q <= pair_en &  cfg_bad;
      end
   end

endmodule

// File: rtl/cpwm_period_ctr.sv
module cpwm_period_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] period_last,
   input  logic [CNT_W-1:0] active_cnt,
   output logic             adv,
   output logic             want_pri
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign adv      = run & tick;
   assign at_end   = (cnt_q >= period_last);
   assign want_pri = (cnt_q < active_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cpwm_dead_gen.sv
module cpwm_dead_gen
   import cpwm_pkg::*;
#(
   parameter int DEAD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              adv,
   input  logic              want_pri,
   input  logic [DEAD_W-1:0] dead_cnt,
   output logic [N_CH-1:0]   act
);

   phase_t            phase_q;
   phase_t            phase_req;
   logic              started_q;
   logic [DEAD_W-1:0] dz_left_q;
   logic              dz_idle;

   assign phase_req = want_pri ? PH_PRI : PH_SEC;
   assign dz_idle   = (dz_left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_SEC;
         started_q <= 1'b0;
         dz_left_q <= '0;
      end else if (!run) begin
         phase_q   <= PH_SEC;
         started_q <= 1'b0;
         dz_left_q <= '0;
      end else if (adv) begin
         started_q <= 1'b1;
         if (!started_q || (phase_req != phase_q)) begin
            phase_q   <= phase_req;
            dz_left_q <= dead_cnt;
         end else if (!dz_idle) begin
            dz_left_q <= dz_left_q - 1'b1;
         end
      end
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam phase_t OWN_PH = (c == CH_PRI) ? PH_PRI : PH_SEC;
      assign act[c] = started_q & (phase_q == OWN_PH) & dz_idle;
   end

endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
   import cpwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DEAD_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [CNT_W-1:0]  period_last,
   input  logic [CNT_W-1:0]  active_cnt,
   input  logic              pri_act_lvl,
   input  logic              dz_en,
   input  logic [DEAD_W-1:0] dead_cnt,
   input  logic              pair_en,
   output logic              pwm_pri,
   output logic              pwm_sec,
   output logic              cfg_err
);

   localparam int DEAD_MAX_W = 8;

   if (DEAD_W < 1 || DEAD_W > DEAD_MAX_W) begin : g_bad_dead_w
      $error("cpwm_pair: DEAD_W must be 1..8");
   end
   if (CNT_W < DEAD_W || CNT_W < 2) begin : g_bad_cnt_w
      $error("cpwm_pair: CNT_W must be >= DEAD_W and >= 2");
   end

   logic            run_q;
   logic            adv;
   logic            want_pri;
   logic [N_CH-1:0] act_raw;
   logic [N_CH-1:0] act_gated;
   logic [N_CH-1:0] act_pin;
   logic [N_CH-1:0] lvl_ch;

   cpwm_cfg_check #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pair_en    (pair_en),
      .dz_en      (dz_en),
      .active_cnt (active_cnt),
      .dead_cnt   (dead_cnt),
      .run_q      (run_q),
      .err_q      (cfg_err)
   );

   cpwm_period_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_q),
      .tick        (tick_en),
      .period_last (period_last),
      .active_cnt  (active_cnt),
      .adv         (adv),
      .want_pri    (want_pri)
   );

   cpwm_dead_gen #(.DEAD_W(DEAD_W)) dz_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .adv      (adv),
      .want_pri (want_pri),
      .dead_cnt (dead_cnt),
      .act      (act_raw)
   );

   assign act_gated = act_raw & {N_CH{run_q}};

   if (OUT_REG) begin : g_out_reg
      logic [N_CH-1:0] act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= '0;
         else        act_q <= act_gated;
      end
      assign act_pin = act_q & {N_CH{run_q}};
   end else begin : g_out_comb
      assign act_pin = act_gated;
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_pin
      localparam bit INV = (c == CH_SEC);
      assign lvl_ch[c] = pin_level(act_pin[c], pri_act_lvl ^ INV);
   end

   assign pwm_pri = lvl_ch[CH_PRI];
   assign pwm_sec = lvl_ch[CH_SEC];

endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk #(
   parameter int CNT_W  = 16,
   parameter int DEAD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  active_cnt,
   input logic              pri_act_lvl,
   input logic              dz_en,
   input logic [DEAD_W-1:0] dead_cnt,
   input logic              pair_en,
   input logic              pwm_pri,
   input logic              pwm_sec,
   input logic              cfg_err
);

   logic pri_on, sec_on, both_off, short_duty;

   assign pri_on     = (pwm_pri == pri_act_lvl);
   assign sec_on     = (pwm_sec != pri_act_lvl);
   assign both_off   = ~pri_on & ~sec_on;
   assign short_duty = (active_cnt < CNT_W'(dead_cnt));

   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dz_en |-> !(pri_on && sec_on));

   assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> both_off);

   assert_short_duty_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en && dz_en && short_duty) |=> cfg_err);

   assert_good_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en && dz_en && !short_duty) |=> !cfg_err);

   assert_dz_off_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en && !dz_en) |=> cfg_err);

   assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_en |=> (both_off && !cfg_err));

endmodule

bind cpwm_pair cpwm_pair_chk #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .active_cnt  (active_cnt),
   .pri_act_lvl (pri_act_lvl),
   .dz_en       (dz_en),
   .dead_cnt    (dead_cnt),
   .pair_en     (pair_en),
   .pwm_pri     (pwm_pri),
   .pwm_sec     (pwm_sec),
   .cfg_err     (cfg_err)
);

// File: tb/cpwm_pair_tb_top.sv
module cpwm_pair_tb_top;

   localparam int CNT_W  = 16;
   localparam int DEAD_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en;
   logic [CNT_W-1:0]  period_last = '0;
   logic [CNT_W-1:0]  active_cnt = '0;
   logic              pri_act_lvl = 1'b1;
   logic              dz_en = 1'b0;
   logic [DEAD_W-1:0] dead_cnt = '0;
   logic              pair_en = 1'b0;
   logic              pwm_pri, pwm_sec, cfg_err;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int tick_div = 1;
   int tick_ph = 0;
   int pa, sb, both, none;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (tick_ph >= tick_div - 1) tick_ph <= 0;
      else                         tick_ph <= tick_ph + 1;
   end
   assign tick_en = (tick_ph == 0);

   cpwm_pair #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .period_last (period_last),
      .active_cnt  (active_cnt),
      .pri_act_lvl (pri_act_lvl),
      .dz_en       (dz_en),
      .dead_cnt    (dead_cnt),
      .pair_en     (pair_en),
      .pwm_pri     (pwm_pri),
      .pwm_sec     (pwm_sec),
      .cfg_err     (cfg_err)
   );

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit pri_on();
      return pwm_pri == pri_act_lvl;
   endfunction
   function automatic bit sec_on();
      return pwm_sec != pri_act_lvl;
   endfunction

   task automatic configure(input int last, input int act, input bit lvl,
                            input bit dz, input int dead, input int div);
      @(negedge clk);
      pair_en = 1'b0;
      repeat (2) @(negedge clk);
      period_last = CNT_W'(last);
      active_cnt  = CNT_W'(act);
      pri_act_lvl = lvl;
      dz_en       = dz;
      dead_cnt    = DEAD_W'(dead);
      tick_div    = div;
      @(negedge clk);
      pair_en = 1'b1;
   endtask

   // Count activity over ncyc samples taken at falling edges.
   task automatic measure(input int settle, input int ncyc);
      pa = 0; sb = 0; both = 0; none = 0;
      repeat (settle) @(negedge clk);
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (pri_on()) pa++;
         if (sec_on()) sb++;
         if (pri_on() && sec_on()) both++;
         if (!pri_on() && !sec_on()) none++;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(pwm_pri == 1'b0, "R1 pri idle level", pwm_pri, 0);
      check(pwm_sec == 1'b1, "R1 sec idle level", pwm_sec, 1);
      check(cfg_err == 1'b0, "R1 err clear", cfg_err, 0);
   endtask

   task automatic t_basic();
      configure(9, 4, 1'b1, 1'b1, 2, 1);
      measure(25, 30);
      check(pa == 6,    "R2 primary active ticks", pa, 6);
      check(sb == 12,   "R3 secondary active ticks", sb, 12);
      check(both == 0,  "R4 no overlap", both, 0);
      check(none == 12, "R5 dead gaps", none, 12);
   endtask

   task automatic t_tick_div();
      configure(7, 5, 1'b1, 1'b1, 1, 3);
      measure(40, 48);
      check(pa == 24,   "R6 primary stretched", pa, 24);
      check(sb == 12,   "R6 secondary stretched", sb, 12);
      check(none == 12, "R6 gaps stretched", none, 12);
   endtask

   task automatic t_low_pol();
      configure(11, 6, 1'b0, 1'b1, 3, 1);
      measure(30, 24);
      check(pa == 6,   "R10 primary active-low ticks", pa, 6);
      check(sb == 6,   "R10 secondary active-high ticks", sb, 6);
      check(both == 0, "R10 no overlap", both, 0);
   endtask

   task automatic t_zero_dead();
      configure(5, 2, 1'b1, 1'b1, 0, 1);
      measure(20, 18);
      check(pa == 6,   "R11 primary ticks", pa, 6);
      check(sb == 12,  "R11 secondary ticks", sb, 12);
      check(none == 0, "R11 no gap", none, 0);
   endtask

   task automatic t_max_dead();
      configure(599, 300, 1'b1, 1'b1, 255, 1);
      measure(1300, 600);
      check(pa == 45,   "R5 max dead primary", pa, 45);
      check(sb == 45,   "R5 max dead secondary", sb, 45);
      check(none == 510, "R5 max dead gaps", none, 510);
   endtask

   task automatic t_short_duty();
      int bad;
      configure(9, 2, 1'b1, 1'b1, 3, 1);
      repeat (2) @(negedge clk);
      check(cfg_err == 1'b1, "R7 err raised", cfg_err, 1);
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pri_on() || sec_on() || !cfg_err) bad++;
      end
      check(bad == 0, "R7 pins inactive while err", bad, 0);
      active_cnt = CNT_W'(5);
      repeat (2) @(negedge clk);
      check(cfg_err == 1'b0, "R7 err cleared", cfg_err, 0);
      measure(20, 20);
      check(pa == 4, "R7 runs after fix", pa, 4);
   endtask

   task automatic t_dz_off();
      int bad;
      configure(9, 5, 1'b1, 1'b0, 1, 1);
      repeat (2) @(negedge clk);
      check(cfg_err == 1'b1, "R8 err raised", cfg_err, 1);
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pri_on() || sec_on()) bad++;
      end
      check(bad == 0, "R8 pins inactive", bad, 0);
   endtask

   task automatic t_restart();
      int n, sec_early;
      configure(9, 4, 1'b1, 1'b1, 2, 1);
      repeat (25) @(negedge clk);
      pair_en = 1'b0;
      @(negedge clk);
      check(!pri_on() && !sec_on(), "R9 idle after disable", pri_on() + 2 * sec_on(), 0);
      check(cfg_err == 1'b0, "R9 err clear when off", cfg_err, 0);
      repeat (3) @(negedge clk);
      pair_en = 1'b1;
      n = 0;
      sec_early = 0;
      while (!pri_on() && n < 50) begin
         @(negedge clk);
         n++;
         if (sec_on()) sec_early++;
      end
      check(n == 4, "R9 first primary latency", n, 4);
      check(sec_early == 0, "R9 secondary held before start", sec_early, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_tick_div();
      t_low_pol();
      t_zero_dead();
      t_short_duty();
      t_dz_off();
      t_restart();
      t_max_dead();
      finish_run();
   end

endmodule